// File: doc/BRIEF.md
# Panel Raster Sync Timing Generator

This block generates the raster timing for a display panel. It produces a line sync, a frame sync, a data-enable strobe and the indices of the current active pixel and active line. A pixel-advance input `pix_en` moves the block forward by one step, and one pulse of it equals one dot-clock period. Every timing interval counts in those steps. Dot-clock generation, pixel fetch and colour handling stay outside the block.

Register-style inputs set the horizontal interval lengths and the vertical interval lengths. They also select passive-matrix mode (STN) or active-matrix mode (TFT), which changes the shape of the frame sync. The block samples all settings together at reset and at each frame boundary, so every frame runs on one consistent set.

The block also flags a setting whose leading horizontal span is too short to cover the fixed pixel-pipeline latency, given as the parameter `LATENCY`.

Top module: `panel_timing_gen`

## Requirements
- R1: Each line starts at step 0. `hsync` (active high) rises VHDLY+1 steps after the line start and stays high for HPW+1 steps.
- R2: The active window of a line starts HBP+1 steps after `hsync` falls and lasts HOZVAL+1 steps. During the window, `pix_x` counts up from 0 to HOZVAL, one per step. Outside the window `pix_x` is 0. HOZVAL must be at least 1.
- R3: After the last active step, HFP+1 further steps pass before the next line starts. A line is therefore VHDLY+HPW+HBP+HOZVAL+HFP+5 steps long.
- R4: With `cfg_stn`=0 (TFT), `vsync` is high for the whole of lines 0 to VPW, starting at step 0 of line 0. Then come exactly VBP blank lines, LINEVAL+1 active lines and exactly VFP blank lines, and the frame ends.
- R5: With `cfg_stn`=1 (STN), the frame has LINEVAL+1 lines and all of them are active. VBP and VFP have no effect. `vsync` rises at the first active step of line 0 and falls at the first active step of line VPW+1. VPW must be less than LINEVAL.
- R6: `den` is high only when the line is in its active window and the line itself is active. `line_y` gives the active-line index from 0 to LINEVAL during active lines and is 0 otherwise.
- R7: A cycle with `pix_en` low changes no output.
- R8: Setting changes take effect only at reset or after the last step of a frame. A change made mid-frame does not affect the current frame.
- R9: `cfg_err` is high exactly when (VHDLY+HPW+HBP+3) × `cfg_dot_period` is less than `LATENCY`, evaluated for the settings of the frame in progress. Equality is legal.
- R10: A cycle with `rst` high at a clock edge puts the block at step 0 of line 0 with the current settings. After that edge, `hsync`=0, `den`=0, `pix_x`=0 and `line_y`=0, and in TFT mode `vsync`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | One pulse per dot-clock period; advances the raster |
| cfg_stn | input | 1 | 1 = STN frame sync behaviour, 0 = TFT |
| cfg_vhdly | input | FW | Line start to line sync delay, minus one |
| cfg_hpw | input | FW | Line sync width, minus one |
| cfg_hbp | input | FW | Line sync end to first active step, minus one |
| cfg_hozval | input | FW | Active steps per line, minus one |
| cfg_hfp | input | FW | Last active step to line end, minus one |
| cfg_vpw | input | FW | Frame sync width in lines, minus one |
| cfg_vbp | input | FW | Blank lines after frame sync (TFT) |
| cfg_lineval | input | FW | Active lines per frame, minus one |
| cfg_vfp | input | FW | Blank lines at frame end (TFT) |
| cfg_dot_period | input | PW | Dot-clock period in controller clocks |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| den | output | 1 | Data enable |
| pix_x | output | CW | Pixel index within the active window |
| line_y | output | CW | Active line index |
| cfg_err | output | 1 | Latency rule violated by the settings in use |

## Verification
The assertions check several behaviours on every cycle:
- `den` never overlaps `hsync`.
- `pix_x` steps by exactly one between adjacent active pixels.
- An idle `pix_en` cycle freezes every output.
- The settings in use never change except at a frame boundary.
- In TFT mode, a sync line never carries data.

Other behaviours can only be shown by the bench's scenarios, which compare against a behavioural position model:
- the exact lengths of each horizontal and vertical interval;
- the alignment of the STN frame sync to the first active step;
- the threshold of the latency flag, including the equality case;
- the deferral of a mid-frame setting change;
- the reset state.

// File: rtl/ptg_pkg.sv
`timescale 1ns/1ps
package ptg_pkg;
    localparam int FW = 8;       // width of each timing field
    localparam int PW = 4;       // width of the dot period field
    localparam int CW = FW + 4;  // position counter width, holds five fields plus five

    typedef struct packed {
        logic          stn;
        logic [FW-1:0] vhdly;
        logic [FW-1:0] hpw;
        logic [FW-1:0] hbp;
        logic [FW-1:0] hozval;
        logic [FW-1:0] hfp;
        logic [FW-1:0] vpw;
        logic [FW-1:0] vbp;
        logic [FW-1:0] lineval;
        logic [FW-1:0] vfp;
    } tcfg_t;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;
endpackage

// File: rtl/ptg_cfg_reg.sv
`timescale 1ns/1ps
module ptg_cfg_reg
    import ptg_pkg::*;
#(
    parameter int LATENCY = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  tcfg_t         cfg_in,
    input  logic [PW-1:0] period,
    output tcfg_t         cfg_q,
    output logic          err_q
);
    localparam int LW = FW + 2;
    localparam int MW = FW + PW + 2;

    typedef struct packed {
        tcfg_t cfg;
        logic  err;
    } creg_t;

    creg_t         s_d, s_q;
    logic [LW-1:0] lead;
    logic [MW-1:0] prod;

    always_comb begin
        lead = LW'(cfg_in.vhdly) + LW'(cfg_in.hpw) + LW'(cfg_in.hbp) + LW'(3);
        prod = MW'(lead) * MW'(period);
        s_d  = s_q;
        if (rst || load) begin
            s_d.cfg = cfg_in;
            if (cfg_in.stn) begin
                s_d.cfg.vbp = '0;
                s_d.cfg.vfp = '0;
            end
            s_d.err = (prod < MW'(LATENCY));
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign cfg_q = s_q.cfg;
    assign err_q = s_q.err;
endmodule

// File: rtl/ptg_hcount.sv
`timescale 1ns/1ps
module ptg_hcount
    import ptg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_en,
    input  logic [FW-1:0] vhdly,
    input  logic [FW-1:0] hpw,
    input  logic [FW-1:0] hbp,
    input  logic [FW-1:0] hozval,
    input  logic [FW-1:0] hfp,
    output logic          hsync,
    output logic          hact,
    output logic          past_start,
    output logic          line_end,
    output logic [CW-1:0] pix_x
);
    ctr_t          h_d, h_q;
    logic [CW-1:0] sync_first, sync_last, act_first, act_last, h_last;

    always_comb begin
        sync_first = CW'(vhdly) + CW'(1);
        sync_last  = CW'(vhdly) + CW'(hpw) + CW'(1);
        act_first  = CW'(vhdly) + CW'(hpw) + CW'(hbp) + CW'(3);
        act_last   = act_first + CW'(hozval);
        h_last     = act_last + CW'(hfp) + CW'(1);

        line_end = pix_en && (h_q.cnt >= h_last);
        h_d      = h_q;
        if (rst)
            h_d.cnt = '0;
        else if (line_end)
            h_d.cnt = '0;
        else if (pix_en)
            h_d.cnt = h_q.cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        h_q <= h_d;
    end

    always_comb begin
        hsync      = (h_q.cnt >= sync_first) && (h_q.cnt <= sync_last);
        past_start = (h_q.cnt >= act_first);
        hact       = past_start && (h_q.cnt <= act_last);
        pix_x      = hact ? (h_q.cnt - act_first) : '0;
    end
endmodule

// File: rtl/ptg_vcount.sv
`timescale 1ns/1ps
module ptg_vcount
    import ptg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          line_adv,
    input  logic          past_start,
    input  logic          stn,
    input  logic [FW-1:0] vpw,
    input  logic [FW-1:0] vbp,
    input  logic [FW-1:0] lineval,
    input  logic [FW-1:0] vfp,
    output logic          vsync,
    output logic          vact,
    output logic          frame_end,
    output logic [CW-1:0] line_y
);
    ctr_t          v_d, v_q;
    logic [CW-1:0] act_first, act_last, v_last, sync_last;

    always_comb begin
        sync_last = CW'(vpw);
        act_first = stn ? '0 : (CW'(vpw) + CW'(vbp) + CW'(1));
        act_last  = act_first + CW'(lineval);
        v_last    = act_last + (stn ? '0 : CW'(vfp));

        frame_end = line_adv && (v_q.cnt >= v_last);
        v_d       = v_q;
        if (rst)
            v_d.cnt = '0;
        else if (frame_end)
            v_d.cnt = '0;
        else if (line_adv)
            v_d.cnt = v_q.cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        v_q <= v_d;
    end

    always_comb begin
        if (stn)
            vsync = ((v_q.cnt == '0) && past_start)
                 || ((v_q.cnt != '0) && (v_q.cnt <= sync_last))
                 || ((v_q.cnt == sync_last + CW'(1)) && !past_start);
        else
            vsync = (v_q.cnt <= sync_last);
        vact   = (v_q.cnt >= act_first) && (v_q.cnt <= act_last);
        line_y = vact ? (v_q.cnt - act_first) : '0;
    end
endmodule

// File: rtl/panel_timing_gen.sv
`timescale 1ns/1ps
module panel_timing_gen
    import ptg_pkg::*;
#(
    parameter int LATENCY = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_en,
    input  logic          cfg_stn,
    input  logic [FW-1:0] cfg_vhdly,
    input  logic [FW-1:0] cfg_hpw,
    input  logic [FW-1:0] cfg_hbp,
    input  logic [FW-1:0] cfg_hozval,
    input  logic [FW-1:0] cfg_hfp,
    input  logic [FW-1:0] cfg_vpw,
    input  logic [FW-1:0] cfg_vbp,
    input  logic [FW-1:0] cfg_lineval,
    input  logic [FW-1:0] cfg_vfp,
    input  logic [PW-1:0] cfg_dot_period,
    output logic          hsync,
    output logic          vsync,
    output logic          den,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] line_y,
    output logic          cfg_err
);
    tcfg_t cfg_in, cfg_q;
    logic  line_end, frame_end, past_start, hact, vact;

    always_comb begin
        cfg_in.stn     = cfg_stn;
        cfg_in.vhdly   = cfg_vhdly;
        cfg_in.hpw     = cfg_hpw;
        cfg_in.hbp     = cfg_hbp;
        cfg_in.hozval  = cfg_hozval;
        cfg_in.hfp     = cfg_hfp;
        cfg_in.vpw     = cfg_vpw;
        cfg_in.vbp     = cfg_vbp;
        cfg_in.lineval = cfg_lineval;
        cfg_in.vfp     = cfg_vfp;
    end

    ptg_cfg_reg #(.LATENCY(LATENCY)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (frame_end),
        .cfg_in (cfg_in),
        .period (cfg_dot_period),
        .cfg_q  (cfg_q),
        .err_q  (cfg_err)
    );

    ptg_hcount u_h (
        .clk        (clk),
        .rst        (rst),
        .pix_en     (pix_en),
        .vhdly      (cfg_q.vhdly),
        .hpw        (cfg_q.hpw),
        .hbp        (cfg_q.hbp),
        .hozval     (cfg_q.hozval),
        .hfp        (cfg_q.hfp),
        .hsync      (hsync),
        .hact       (hact),
        .past_start (past_start),
        .line_end   (line_end),
        .pix_x      (pix_x)
    );

    ptg_vcount u_v (
        .clk        (clk),
        .rst        (rst),
        .line_adv   (line_end),
        .past_start (past_start),
        .stn        (cfg_q.stn),
        .vpw        (cfg_q.vpw),
        .vbp        (cfg_q.vbp),
        .lineval    (cfg_q.lineval),
        .vfp        (cfg_q.vfp),
        .vsync      (vsync),
        .vact       (vact),
        .frame_end  (frame_end),
        .line_y     (line_y)
    );

    assign den = hact && vact;
endmodule

// File: rtl/ptg_checker.sv
`timescale 1ns/1ps
module ptg_checker
    import ptg_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          pix_en,
    input logic          hsync,
    input logic          vsync,
    input logic          den,
    input logic [CW-1:0] pix_x,
    input logic [CW-1:0] line_y,
    input logic          frame_end,
    input tcfg_t         cfg_q
);
    assert_den_clear_of_sync_R2: assert property (@(posedge clk) disable iff (rst)
        den |-> !hsync);

    assert_pixel_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pix_en && den && (pix_x != CW'(cfg_q.hozval)))
        |=> (den && (pix_x == $past(pix_x) + CW'(1))));

    assert_index_bound_R6: assert property (@(posedge clk) disable iff (rst)
        den |-> ((pix_x <= CW'(cfg_q.hozval)) && (line_y <= CW'(cfg_q.lineval))));

    assert_idle_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(hsync) && $stable(vsync) && $stable(den)
                     && $stable(pix_x) && $stable(line_y)));

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(cfg_q));

    assert_tft_sync_blank_R4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.stn && vsync) |-> (!den && (line_y == '0)));
endmodule

bind panel_timing_gen ptg_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_en    (pix_en),
    .hsync     (hsync),
    .vsync     (vsync),
    .den       (den),
    .pix_x     (pix_x),
    .line_y    (line_y),
    .frame_end (frame_end),
    .cfg_q     (cfg_q)
);

// File: tb/test_panel_timing_gen.sv
`timescale 1ns/1ps
module test_panel_timing_gen;
    localparam int LAT = 12;

    logic        clk = 1'b0;
    logic        rst, pix_en, cfg_stn;
    logic [7:0]  cfg_vhdly, cfg_hpw, cfg_hbp, cfg_hozval, cfg_hfp;
    logic [7:0]  cfg_vpw, cfg_vbp, cfg_lineval, cfg_vfp;
    logic [3:0]  cfg_dot_period;
    logic        hsync, vsync, den, cfg_err;
    logic [11:0] pix_x, line_y;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string scen = "init";

    // behavioural model state: position and settings in force
    int mx, my;
    int m_stn, m_vhdly, m_hpw, m_hbp, m_hozval, m_hfp, m_vpw, m_vbp, m_lineval, m_vfp, m_per;
    bit prev_en, prev_rst;
    logic p_hs, p_vs, p_den;
    logic [11:0] p_px, p_ly;

    always #4 clk = ~clk;

    panel_timing_gen #(.LATENCY(LAT)) i_panel_timing_gen (
        .clk(clk), .rst(rst), .pix_en(pix_en), .cfg_stn(cfg_stn),
        .cfg_vhdly(cfg_vhdly), .cfg_hpw(cfg_hpw), .cfg_hbp(cfg_hbp),
        .cfg_hozval(cfg_hozval), .cfg_hfp(cfg_hfp), .cfg_vpw(cfg_vpw),
        .cfg_vbp(cfg_vbp), .cfg_lineval(cfg_lineval), .cfg_vfp(cfg_vfp),
        .cfg_dot_period(cfg_dot_period), .hsync(hsync), .vsync(vsync),
        .den(den), .pix_x(pix_x), .line_y(line_y), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] t=%0t: actual %0d expected %0d", tag, scen, $time, act, exp);
        end
    endtask

    task automatic set_cfg(input int stn, input int vh, input int hp, input int hb,
                           input int hz, input int hf, input int vp, input int vb,
                           input int lv, input int vf, input int per);
        cfg_stn = 1'(stn);   cfg_vhdly = 8'(vh); cfg_hpw = 8'(hp); cfg_hbp = 8'(hb);
        cfg_hozval = 8'(hz); cfg_hfp = 8'(hf);   cfg_vpw = 8'(vp); cfg_vbp = 8'(vb);
        cfg_lineval = 8'(lv); cfg_vfp = 8'(vf);  cfg_dot_period = 4'(per);
    endtask

    task automatic take_cfg();
        m_stn = cfg_stn; m_vhdly = cfg_vhdly; m_hpw = cfg_hpw; m_hbp = cfg_hbp;
        m_hozval = cfg_hozval; m_hfp = cfg_hfp; m_vpw = cfg_vpw;
        m_vbp = m_stn ? 0 : int'(cfg_vbp);
        m_vfp = m_stn ? 0 : int'(cfg_vfp);
        m_lineval = cfg_lineval; m_per = cfg_dot_period;
    endtask

    function automatic int act0();
        return m_vhdly + m_hpw + m_hbp + 3;
    endfunction
    function automatic int line_len();
        return act0() + m_hozval + 1 + m_hfp + 1;
    endfunction
    function automatic int voff();
        return m_stn ? 0 : m_vpw + 1 + m_vbp;
    endfunction
    function automatic int frame_lines();
        return voff() + m_lineval + 1 + m_vfp;
    endfunction

    // model of the coming clock edge with the inputs now driven
    task automatic model_edge();
        if (rst) begin
            mx = 0; my = 0; take_cfg();
        end else if (pix_en) begin
            if (mx == line_len() - 1) begin
                mx = 0;
                if (my == frame_lines() - 1) begin
                    my = 0; take_cfg();
                end else my++;
            end else mx++;
        end
    endtask

    task automatic compare();
        int  a = act0();
        bit  e_hs = (mx >= m_vhdly + 1) && (mx <= m_vhdly + m_hpw + 1);
        bit  e_ha = (mx >= a) && (mx <= a + m_hozval);
        bit  e_va = (my >= voff()) && (my <= voff() + m_lineval);
        int  e_px = e_ha ? mx - a : 0;
        int  e_ly = e_va ? my - voff() : 0;
        int  pos  = my * line_len() + mx;
        bit  e_vs;
        bit  e_err = ((m_vhdly + m_hpw + m_hbp + 3) * m_per) < LAT;
        if (m_stn) e_vs = (pos >= a) && (pos < (m_vpw + 1) * line_len() + a);
        else       e_vs = (my <= m_vpw);
        chk(hsync === e_hs, "R1 R3 hsync", int'(hsync), int'(e_hs));
        chk(den === (e_ha && e_va), "R6 den", int'(den), int'(e_ha && e_va));
        chk(pix_x === 12'(e_px), "R2 pix_x", int'(pix_x), e_px);
        chk(line_y === 12'(e_ly), "R6 line_y", int'(line_y), e_ly);
        if (m_stn) chk(vsync === e_vs, "R5 vsync", int'(vsync), int'(e_vs));
        else       chk(vsync === e_vs, "R4 vsync", int'(vsync), int'(e_vs));
        chk(cfg_err === e_err, "R9 cfg_err", int'(cfg_err), int'(e_err));
        if (!prev_en && !prev_rst)
            chk({hsync, vsync, den, pix_x, line_y} === {p_hs, p_vs, p_den, p_px, p_ly},
                "R7 idle step", int'(den), int'(p_den));
        p_hs = hsync; p_vs = vsync; p_den = den; p_px = pix_x; p_ly = line_y;
    endtask

    task automatic cycle(input bit en, input bit r);
        pix_en = en; rst = r;
        model_edge();
        prev_en = en; prev_rst = r;
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n, input bit rnd);
        for (int i = 0; i < n; i++) cycle(rnd ? 1'($urandom % 2) : 1'b1, 1'b0);
    endtask

    initial begin
        // TFT: line 16 steps, frame 9 lines, lead 7 x period 4 = 28, legal
        set_cfg(0, 1, 2, 1, 5, 2, 1, 2, 3, 1, 4);
        scen = "tft_base";
        cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b1);
        // R10 reset state
        chk(hsync === 1'b0, "R10 hsync after reset", int'(hsync), 0);
        chk(den === 1'b0, "R10 den after reset", int'(den), 0);
        chk(pix_x === 12'd0 && line_y === 12'd0, "R10 indices after reset", int'(pix_x), 0);
        chk(vsync === 1'b1, "R10 tft vsync after reset", int'(vsync), 1);
        run(200, 1'b0);
        // R8: change mid-frame; model defers it to the frame boundary
        scen = "R8 mid-frame change, then minimum sizes, lead 4 x 3 = 12 legal";
        set_cfg(0, 0, 0, 1, 1, 0, 0, 0, 1, 0, 3);
        run(300, 1'b0);
        scen = "R9 lead 3 x 1 below latency";
        set_cfg(0, 0, 0, 0, 1, 0, 0, 0, 1, 0, 1);
        run(100, 1'b0);
        chk(cfg_err === 1'b1, "R9 flag raised", int'(cfg_err), 1);
        // STN with porches that must be ignored, random idle steps
        scen = "R5 stn random pix_en";
        set_cfg(1, 2, 1, 0, 3, 1, 1, 3, 4, 2, 2);
        run(900, 1'b1);
        // R10 reset mid-frame back to TFT base
        scen = "R10 mid-frame reset";
        set_cfg(0, 1, 2, 1, 5, 2, 1, 2, 3, 1, 4);
        cycle(1'b1, 1'b1);
        chk(hsync === 1'b0 && den === 1'b0, "R10 outputs after reset", int'(den), 0);
        chk(cfg_err === 1'b0, "R10 settings taken at reset", int'(cfg_err), 0);
        run(400, 1'b1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog [%s]: actual 0 expected 1", scen);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule